// File: doc/BRIEF.md
# Shared Global Timer with Banked Per-Core Comparators

This block is a memory-mapped global timer. A single 64-bit up-counter is shared by up to four processor cores. A programmable prescaler paces the counter. Each core owns a private bank, which holds:

- a 64-bit comparator,
- a 32-bit reload step,
- three control bits,
- a sticky event flag,
- an interrupt line.

A core's comparator fires whenever the shared count has reached or passed it. With reload enabled, the comparator then moves forward by the step, which gives a periodic tick.

Access is over a simple single-cycle 32-bit register bus. A core-ID input selects the bank that the banked registers refer to, so every core sees the same eight word offsets. The control word is split in two:

- the run bit and the prescaler are common to all cores;
- compare enable, interrupt enable and reload enable belong to the calling core.

Read data is registered and appears one cycle after the request.

Top module: `gtimer_shared`

## Requirements
- R1: While the run bit (control bit 0) is set, the counter rises by one every (prescaler + 1) clock cycles, where the prescaler is control bits 15:8. While the run bit is clear, the counter holds its value.
- R2: A core's comparator takes no action unless both the shared run bit and that core's compare-enable bit (control bit 1) are set.
- R3: When compare is active and the count is greater than or equal to a core's 64-bit comparator, that core's status flag (status bit 0) is set at the next clock edge. The flag stays set until it is cleared.
- R4: When a core's reload bit (control bit 3) is set, each compare event adds that core's 32-bit step to its comparator. With the reload bit clear, the comparator is left unchanged.
- R5: Each core's interrupt output equals its status flag ANDed with its interrupt-enable bit (control bit 2).
- R6: Writing status with bit 0 at 1 clears the calling core's flag. Writing it with bit 0 at 0 leaves the flag as it was.
- R7: The counter halves (offset 0x00 low, 0x04 high) can be written only while the run bit is clear. Writes made while it is set are dropped.
- R8: A control read (offset 0x08) returns the shared run and prescaler bits ORed with the calling core's own banked bits. A control write updates the shared bits and only the calling core's banked bits.
- R9: The comparator (0x10 low, 0x14 high) and the step (0x18) are kept separately for each core and read back as written. Read data is valid one cycle after the request.
- R10: An access to offset 0x1C, or to any address whose two low bits are not zero, reads as zero and changes nothing.
- R11: Reset clears the counter, the shared control bits, and every core's control bits, flag, comparator and step. All interrupt outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_core | input | CORE_W | Calling core, selects the bank |
| bus_addr | input | 5 | Byte offset inside the 32-byte window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq | output | NUM_CORES | Per-core interrupt lines |

## Verification
The bench builds the block with three cores. This makes the core-ID field two bits wide with one unused code, and it exposes every bank to writes from its neighbours, so cross-bank leakage shows up at the ports.

A zero prescaler makes comparator hits land on predictable cycles. This allows the equality edge of the greater-or-equal match to be sampled exactly, and the comparator's reload position to be predicted from the elapsed cycle count. Random prescaler values check the division ratio.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned PS_W    = 8;

  localparam logic [IDX_W-1:0] IDX_CNT_LO = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CNT_HI = 3'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_STAT   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CMP_LO = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CMP_HI = 3'd5;
  localparam logic [IDX_W-1:0] IDX_STEP   = 3'd6;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_CMPEN = 1;
  localparam int unsigned BIT_IRQEN = 2;
  localparam int unsigned BIT_RELD  = 3;
  localparam int unsigned PS_LSB    = 8;

  typedef struct packed {
    logic reload;
    logic irq_en;
    logic cmp_en;
  } bank_ctl_t;
endpackage

// File: rtl/gtm_prescaler.sv
module gtm_prescaler #(
  parameter int unsigned PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps_val,
  output logic            tick
);
  logic [PS_W-1:0] div_q;
  logic            wrap;

  assign wrap = (div_q >= ps_val);
  assign tick = run & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (!run || wrap) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= cnt_q + 1'b1;
    end else if (wr_lo) begin
      cnt_q[DATA_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt_q[CNT_W-1:DATA_W] <= wdata;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/gtm_bank.sv
module gtm_bank
  import gtm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_ctl,
  input  logic              wr_stat,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              wr_step,
  output bank_ctl_t         ctl,
  output logic              status,
  output logic [CNT_W-1:0]  cmp,
  output logic [DATA_W-1:0] step,
  output logic              irq
);
  bank_ctl_t         ctl_q, ctl_d;
  logic              stat_q, stat_d;
  logic [CNT_W-1:0]  cmp_q;
  logic [DATA_W-1:0] step_q;
  logic              irq_q;
  logic              hit;

  assign hit = run & ctl_q.cmp_en & (count >= cmp_q);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.cmp_en = wdata[BIT_CMPEN];
      ctl_d.irq_en = wdata[BIT_IRQEN];
      ctl_d.reload = wdata[BIT_RELD];
    end
    stat_d = hit | (stat_q & ~(wr_stat & wdata[0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      stat_q <= 1'b0;
      cmp_q  <= '0;
      step_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      irq_q  <= stat_d & ctl_d.irq_en;
      if (wr_step) step_q <= wdata;
      if (wr_cmp_lo) begin
        cmp_q[DATA_W-1:0] <= wdata;
      end else if (wr_cmp_hi) begin
        cmp_q[CNT_W-1:DATA_W] <= wdata;
      end else if (hit && ctl_q.reload) begin
        cmp_q <= cmp_q + {{(CNT_W-DATA_W){1'b0}}, step_q};
      end
    end
  end

  assign ctl    = ctl_q;
  assign status = stat_q;
  assign cmp    = cmp_q;
  assign step   = step_q;
  assign irq    = irq_q;
endmodule

// File: rtl/gtimer_shared.sv
module gtimer_shared
  import gtm_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned CNT_W    = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [CORE_W-1:0]    bus_core,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] irq
);
  logic [IDX_W-1:0] idx;
  logic             aligned, core_ok, wr, rd;
  logic             run_q;
  logic [PS_W-1:0]  ps_q;
  logic             tick;
  logic [CNT_W-1:0] count_q;
  logic [DATA_W-1:0] rd_d, rdata_q;

  bank_ctl_t                        ctl_vec  [NUM_CORES];
  logic [NUM_CORES-1:0]             status_vec, cmpen_vec, ie_vec;
  logic [NUM_CORES-1:0][CNT_W-1:0]  cmp_arr;
  logic [DATA_W-1:0]                step_arr [NUM_CORES];

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign core_ok = ({1'b0, bus_core} < NUM_CORES[CORE_W:0]);
  assign wr      = bus_sel & bus_we & aligned;
  assign rd      = bus_sel & ~bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ps_q  <= '0;
    end else if (wr && idx == IDX_CTRL) begin
      run_q <= bus_wdata[BIT_RUN];
      ps_q  <= bus_wdata[PS_LSB +: PS_W];
    end
  end

  gtm_prescaler #(.PS_W(PS_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .ps_val (ps_q),
    .tick   (tick)
  );

  gtm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .tick  (tick),
    .wr_lo (wr && idx == IDX_CNT_LO),
    .wr_hi (wr && idx == IDX_CNT_HI),
    .wdata (bus_wdata),
    .count (count_q)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
    logic mine;
    assign mine = wr & core_ok & (bus_core == CORE_W'(g));

    gtm_bank #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .run       (run_q),
      .count     (count_q),
      .wdata     (bus_wdata),
      .wr_ctl    (mine && idx == IDX_CTRL),
      .wr_stat   (mine && idx == IDX_STAT),
      .wr_cmp_lo (mine && idx == IDX_CMP_LO),
      .wr_cmp_hi (mine && idx == IDX_CMP_HI),
      .wr_step   (mine && idx == IDX_STEP),
      .ctl       (ctl_vec[g]),
      .status    (status_vec[g]),
      .cmp       (cmp_arr[g]),
      .step      (step_arr[g]),
      .irq       (irq[g])
    );

    assign cmpen_vec[g] = ctl_vec[g].cmp_en;
    assign ie_vec[g]    = ctl_vec[g].irq_en;
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      case (idx)
        IDX_CNT_LO: rd_d = count_q[DATA_W-1:0];
        IDX_CNT_HI: rd_d = count_q[CNT_W-1:DATA_W];
        IDX_CTRL: begin
          rd_d[BIT_RUN]            = run_q;
          rd_d[PS_LSB +: PS_W]     = ps_q;
        end
        default: rd_d = '0;
      endcase
      for (int k = 0; k < NUM_CORES; k++) begin
        if (core_ok && bus_core == CORE_W'(k)) begin
          case (idx)
            IDX_CTRL: begin
              rd_d[BIT_CMPEN] = ctl_vec[k].cmp_en;
              rd_d[BIT_IRQEN] = ctl_vec[k].irq_en;
              rd_d[BIT_RELD]  = ctl_vec[k].reload;
            end
            IDX_STAT:   rd_d = {{(DATA_W-1){1'b0}}, status_vec[k]};
            IDX_CMP_LO: rd_d = cmp_arr[k][DATA_W-1:0];
            IDX_CMP_HI: rd_d = cmp_arr[k][CNT_W-1:DATA_W];
            IDX_STEP:   rd_d = step_arr[k];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rd_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gtm_checker.sv
module gtm_checker #(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned CNT_W    = 2 * DATA_W
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_sel,
  input logic                          bus_we,
  input logic [CORE_W-1:0]             bus_core,
  input logic [4:0]                    bus_addr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic                          run,
  input logic [CNT_W-1:0]              count,
  input logic [NUM_CORES-1:0]          status,
  input logic [NUM_CORES-1:0]          cmpen,
  input logic [NUM_CORES-1:0]          ie,
  input logic [NUM_CORES-1:0][CNT_W-1:0] cmp,
  input logic [NUM_CORES-1:0]          irq
);
  logic cnt_wr;
  assign cnt_wr = bus_sel & bus_we & (bus_addr[4:3] == 2'b00);

  // R1: counter moves by at most one per cycle while running
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    run |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R7: stopped and not written means frozen
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> (count == $past(count)));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic clr;
    assign clr = bus_sel & bus_we & (bus_addr == 5'h0C) &
                 (bus_core == CORE_W'(i)) & bus_wdata[0];

    // R3: greater-or-equal match raises the flag next cycle
    p_hit_sets_r3: assert property (@(posedge clk) disable iff (rst)
      (run && cmpen[i] && count >= cmp[i]) |=> status[i]);

    // R2: inactive compare never raises a clear flag
    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      ((!run || !cmpen[i]) && !status[i]) |=> !status[i]);

    // R5: interrupt line mirrors flag and enable
    p_irq_r5: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (status[i] && ie[i]));

    // R6: flag survives anything but a write of one to bit 0
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !clr) |=> status[i]);
  end
endmodule

bind gtimer_shared gtm_checker #(
  .NUM_CORES (NUM_CORES),
  .DATA_W    (DATA_W)
) u_gtm_checker (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_core  (bus_core),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run       (run_q),
  .count     (count_q),
  .status    (status_vec),
  .cmpen     (cmpen_vec),
  .ie        (ie_vec),
  .cmp       (cmp_arr),
  .irq       (irq)
);

// File: tb/test_gtimer_shared.sv
`timescale 1ns/1ps
module test_gtimer_shared;
  localparam int NC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_core = '0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int unsigned checks = 0;
  int unsigned fails = 0;
  bit          done = 1'b0;

  logic [63:0] m_cmp [NC];
  logic [31:0] m_step [NC];

  always #2 clk = ~clk;

  gtimer_shared #(.NUM_CORES(NC), .DATA_W(32)) i_gtimer_shared (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int core, input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_core = 2'(core); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int core, input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_core = 2'(core); bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] cnt_after(input int edges, input int ps);
    return 32'(edges / (ps + 1));
  endfunction

  function automatic logic [31:0] reload_pos(input int c0, input int st, input int fin);
    int k;
    k = (fin - 1 >= c0) ? ((fin - 1 - c0) / st + 1) : 0;
    return 32'(c0 + st * k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R11: reset state of every register and line
    for (int c = 0; c < NC; c++) begin
      for (int o = 0; o < 7; o++) begin
        rd(c, 5'(o * 4), v);
        chk("R11", v, 0);
      end
      m_cmp[c] = '0; m_step[c] = '0;
    end
    chk("R11 irq", irq, 0);

    // R9: random bank writes and readback
    for (int n = 0; n < 15; n++) begin
      int c, w;
      c = $urandom_range(0, NC - 1);
      w = $urandom_range(0, 2);
      v = $urandom;
      if (w == 0) begin wr(c, 5'h10, v); m_cmp[c][31:0] = v; end
      else if (w == 1) begin wr(c, 5'h14, v); m_cmp[c][63:32] = v; end
      else begin wr(c, 5'h18, v); m_step[c] = v; end
    end
    for (int c = 0; c < NC; c++) begin
      rd(c, 5'h10, v); chk("R9 cmp_lo", v, m_cmp[c][31:0]);
      rd(c, 5'h14, v); chk("R9 cmp_hi", v, m_cmp[c][63:32]);
      rd(c, 5'h18, v); chk("R9 step", v, m_step[c]);
    end

    // R8: shared and banked control
    wr(0, 5'h08, 32'h0000_0506);
    wr(1, 5'h08, 32'h0000_0908);
    rd(0, 5'h08, v); chk("R8 core0", v, 32'h906);
    rd(1, 5'h08, v); chk("R8 core1", v, 32'h908);
    rd(2, 5'h08, v); chk("R8 core2", v, 32'h900);

    // R10: unmapped and misaligned
    wr(0, 5'h1C, $urandom);
    wr(0, 5'h09, 32'hFFFF_FFFF);
    rd(0, 5'h08, v); chk("R10 ctrl kept", v, 32'h906);
    rd(0, 5'h1C, v); chk("R10 read 1C", v, 0);
    rd(0, 5'h0D, v); chk("R10 misaligned", v, 0);
    rd(0, 5'h10, v); chk("R10 cmp kept", v, m_cmp[0][31:0]);

    // R7: load while stopped, ignore while running
    lo = $urandom_range(0, 32'hFFFF_0000);
    hi = $urandom;
    wr(2, 5'h00, lo); wr(2, 5'h04, hi);
    rd(2, 5'h00, v); chk("R7 load lo", v, lo);
    rd(2, 5'h04, v); chk("R7 load hi", v, hi);
    wr(2, 5'h08, 32'h1);
    wr(2, 5'h00, 32'h0);
    wr(2, 5'h08, 32'h0);
    rd(2, 5'h00, v); chk("R7 ignored lo", v, lo + 2);
    rd(2, 5'h04, v); chk("R7 ignored hi", v, hi);

    // R1: prescaler ratios
    for (int t = 0; t < 4; t++) begin
      int p, d;
      p = (t == 0) ? 0 : (t == 1) ? 3 : $urandom_range(1, 12);
      d = $urandom_range(20, 90);
      wr(2, 5'h00, 0); wr(2, 5'h04, 0);
      wr(2, 5'h08, 32'((p << 8) | 1));
      repeat (d) @(negedge clk);
      wr(2, 5'h08, 32'(p << 8));
      rd(2, 5'h00, v); chk("R1 prescale", v, cnt_after(d + 1, p));
    end

    // cleanup
    for (int c = 0; c < NC; c++) begin wr(c, 5'h08, 0); wr(c, 5'h0C, 1); end
    chk("R6 cleared irq", irq, 0);

    // R3/R2/R5: exact equality edge
    wr(0, 5'h10, 30); wr(0, 5'h14, 0);
    wr(1, 5'h10, 30); wr(1, 5'h14, 0);
    wr(1, 5'h08, 32'h4);
    wr(0, 5'h00, 0); wr(0, 5'h04, 0);
    wr(0, 5'h08, 32'h7);
    chk("R3 none at start", irq, 0);
    repeat (30) @(negedge clk);
    chk("R3 below compare", irq[0], 0);
    @(negedge clk);
    chk("R3 R5 equal hit", irq[0], 1);
    chk("R2 no cmp_en", irq[1], 0);
    wr(0, 5'h08, 32'h6);
    rd(1, 5'h0C, v); chk("R2 status core1", v, 0);
    rd(0, 5'h0C, v); chk("R3 status core0", v, 1);
    rd(0, 5'h10, v); chk("R4 no reload", v, 30);

    // R6: write-one-to-clear
    wr(0, 5'h0C, 0);
    rd(0, 5'h0C, v); chk("R6 zero write", v, 1);
    wr(0, 5'h0C, 32'hFFFF_FFFE);
    rd(0, 5'h0C, v); chk("R6 bit0 clear write", v, 1);
    chk("R6 irq held", irq[0], 1);
    wr(0, 5'h0C, 1);
    chk("R6 irq dropped", irq[0], 0);
    rd(0, 5'h0C, v); chk("R6 cleared", v, 0);

    // R5: flag without enable
    wr(0, 5'h08, 32'h3);
    repeat (3) @(negedge clk);
    chk("R5 masked", irq[0], 0);
    rd(0, 5'h0C, v); chk("R5 flag set", v, 1);
    wr(0, 5'h08, 32'h6);
    chk("R5 unmasked", irq[0], 1);
    wr(0, 5'h08, 0); wr(0, 5'h0C, 1);

    // R4: reload, directed then random
    for (int t = 0; t < 3; t++) begin
      int c0, st, d;
      c0 = (t == 0) ? 10 : $urandom_range(5, 30);
      st = (t == 0) ? 7 : $urandom_range(1, 20);
      d  = (t == 0) ? 40 : $urandom_range(40, 120);
      wr(2, 5'h10, 32'(c0)); wr(2, 5'h14, 0); wr(2, 5'h18, 32'(st));
      wr(2, 5'h00, 0); wr(2, 5'h04, 0);
      wr(2, 5'h08, 32'hB);
      repeat (d) @(negedge clk);
      wr(2, 5'h08, 32'hA);
      rd(2, 5'h00, v); chk("R1 count", v, 32'(d + 1));
      rd(2, 5'h10, v); chk("R4 reload lo", v, reload_pos(c0, st, d + 1));
      rd(2, 5'h14, v); chk("R4 reload hi", v, 0);
      rd(2, 5'h0C, v); chk("R3 periodic flag", v, 1);
      wr(2, 5'h0C, 1); wr(2, 5'h08, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule